// File: doc/BRIEF.md
# Two-Stage Signed-Digit Result Combiner

This block sits beside one column of a two-stage cyclic converter and turns the comparator decisions of both stages into a single 12-bit binary result per pixel. Each decision is a ternary digit (−1, 0 or +1) delivered as a two-bit thermometer code with a strobe. The first stage yields four digits per pixel and the second stage eight more. Because the stages are pipelined, the first stage may already be producing digits for the next pixel while the second stage is still working on the current one.

The front collector adds the first-stage digits into a signed partial sum. When the transfer-switch control falls, that partial sum is handed to the back collector, and the front starts on the next pixel. The back collector adds the eight second-stage digits, adds the mid-scale offset, clamps the value to the 12-bit range and presents it with a one-cycle valid pulse. An illegal comparator pattern counts as zero and sets a sticky error flag.

Front states: `F_FILL` (accepting first-stage digits) and `F_FULL` (all first-stage digits held, further ones ignored). Front transitions: `F_FILL→F_FULL` when the last first-stage digit is accepted; `F_FULL→F_FILL` and `F_FILL→F_FILL` on a hand-off. Back states: `B_IDLE` (no pixel pending) and `B_COLLECT` (adding second-stage digits). Back transitions: `B_IDLE→B_COLLECT` on a hand-off; `B_COLLECT→B_IDLE` on the eighth second-stage digit; `B_COLLECT→B_COLLECT` when a new hand-off restarts collection.

Top module: `redundant_digit_combiner`

## Requirements
- R1: While reset is held and after its release, `res_valid`, `res_word` and `code_err` are 0.
- R2: Codes decode as 00 = −1, 01 = 0, 11 = +1. The first-stage digit with index k (k = 0 first) weighs 2^(11−k), and the second-stage digit with index j (j = 0 first) weighs 2^(7−j). The result is 2048 plus the signed weighted sum.
- R3: The result is clamped to the range 0 to 4095. For example, all +1 digits give 4095 and all −1 digits give 0.
- R4: A hand-off occurs in a cycle where `xfer_on` is 0 and was 1 in the previous cycle. A first-stage digit strobed in that same cycle becomes digit 0 of the next pixel.
- R5: First-stage digits strobed after four have been accepted, and before the next hand-off, have no effect.
- R6: The front can collect the next pixel's first-stage digits while the back collects the current pixel's second-stage digits, and both results are correct.
- R7: `res_valid` is a one-cycle pulse in the cycle after the eighth second-stage digit, with `res_word` holding the result. `res_word` keeps its value until the next result.
- R8: Second-stage digits have no effect when no pixel is pending, and also in the hand-off cycle itself.
- R9: The code 10 counts as 0 and sets `code_err`. The flag stays set until reset.
- R10: If a hand-off comes after fewer than four first-stage digits, the missing digits count as 0.
- R11: A hand-off while the back is still collecting discards the partial pixel without a valid pulse and starts the new pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s1_stb | input | 1 | First-stage digit strobe |
| s1_code | input | 2 | First-stage thermometer code |
| xfer_on | input | 1 | Transfer-switch control; its fall triggers the hand-off |
| s2_stb | input | 1 | Second-stage digit strobe |
| s2_code | input | 2 | Second-stage thermometer code |
| res_valid | output | 1 | One-cycle result strobe |
| res_word | output | 12 | Clamped binary result |
| code_err | output | 1 | Sticky flag for an illegal code |

## Verification
The hardest situation to reach is the overlap of two pixels. In it, the next pixel's first digit arrives in the same cycle as the hand-off, its remaining first-stage digits interleave with the current pixel's second-stage digits, and the next transfer fall lands in the cycle where the previous result is shown. Directed sequences build exactly that schedule, and a restart during second-stage collection as well. Random digit streams then cover the weighted sum, while all-+1 and all-−1 pixels push the sum into both clamps.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    typedef enum logic {
        F_FILL,
        F_FULL
    } front_state_t;

    typedef enum logic {
        B_IDLE,
        B_COLLECT
    } back_state_t;

    typedef enum logic [1:0] {
        DIG_NEG  = 2'b00,
        DIG_ZERO = 2'b01,
        DIG_BAD  = 2'b10,
        DIG_POS  = 2'b11
    } therm_t;
endpackage

// File: rtl/rdc_decode.sv
module rdc_decode
    import rdc_pkg::*;
(
    input  logic [1:0] code,
    output logic       is_pos,
    output logic       is_neg,
    output logic       is_bad
);
    always_comb begin
        is_pos = 1'b0;
        is_neg = 1'b0;
        is_bad = 1'b0;
        unique case (therm_t'(code))
            DIG_NEG:  is_neg = 1'b1;
            DIG_ZERO: ;
            DIG_BAD:  is_bad = 1'b1;
            DIG_POS:  is_pos = 1'b1;
        endcase
    end
endmodule

// File: rtl/rdc_front.sv
module rdc_front
    import rdc_pkg::*;
#(
    parameter int N1   = 4,
    parameter int NTOT = 12,
    parameter int SW   = NTOT + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dig_stb,
    input  logic                 dig_pos,
    input  logic                 dig_neg,
    input  logic                 xfer_on,
    output logic                 ho_load,
    output logic signed [SW-1:0] ho_sum
);
    localparam int CW = $clog2(N1 + 1);
    localparam logic signed [SW-1:0] ONE = 1;

    front_state_t         state, state_nxt;
    logic                 xfer_q;
    logic [CW-1:0]        cnt;
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] step, step0;
    logic                 fall;

    function automatic logic signed [SW-1:0] signed_wt(input int idx, input logic p, input logic n);
        logic signed [SW-1:0] w;
        w = ONE <<< (NTOT - 1 - idx);
        if (p)      return w;
        else if (n) return -w;
        else        return '0;
    endfunction

    assign fall    = xfer_q && !xfer_on;
    assign step    = signed_wt(int'(cnt), dig_pos, dig_neg);
    assign step0   = signed_wt(0, dig_pos, dig_neg);
    assign ho_load = fall;
    assign ho_sum  = acc;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= F_FILL;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            F_FILL: begin
                if (fall)
                    state_nxt = (dig_stb && N1 == 1) ? F_FULL : F_FILL;
                else if (dig_stb && cnt == CW'(N1 - 1))
                    state_nxt = F_FULL;
            end
            F_FULL: begin
                if (fall)
                    state_nxt = (dig_stb && N1 == 1) ? F_FULL : F_FILL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q <= 1'b0;
            cnt    <= '0;
            acc    <= '0;
        end else begin
            xfer_q <= xfer_on;
            if (fall) begin
                acc <= dig_stb ? step0 : '0;
                cnt <= dig_stb ? CW'(1) : '0;
            end else if (state == F_FILL && dig_stb) begin
                acc <= acc + step;
                cnt <= cnt + CW'(1);
            end
        end
    end

    a_r5_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state == F_FULL && !fall) |=> $stable(acc));
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(N1));
    a_r4_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
        ho_load |=> (cnt <= CW'(1)));
endmodule

// File: rtl/rdc_back.sv
module rdc_back
    import rdc_pkg::*;
#(
    parameter int N2   = 8,
    parameter int NTOT = 12,
    parameter int SW   = NTOT + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ho_load,
    input  logic signed [SW-1:0] ho_sum,
    input  logic                 dig_stb,
    input  logic                 dig_pos,
    input  logic                 dig_neg,
    output logic                 res_valid,
    output logic [NTOT-1:0]      res_word
);
    localparam int CW = $clog2(N2 + 1);
    localparam logic signed [SW-1:0] ONE    = 1;
    localparam logic signed [SW-1:0] OFFSET = ONE <<< (NTOT - 1);
    localparam logic signed [SW-1:0] MAXV   = (ONE <<< NTOT) - ONE;

    back_state_t          state, state_nxt;
    logic [CW-1:0]        cnt;
    logic signed [SW-1:0] acc, step, total, biased;
    logic [NTOT-1:0]      clamped;
    logic                 take, last;

    always_comb begin
        step = ONE <<< (N2 - 1 - int'(cnt));
        if (dig_neg)      step = -step;
        else if (!dig_pos) step = '0;
    end

    assign take   = (state == B_COLLECT) && dig_stb && !ho_load;
    assign last   = take && (cnt == CW'(N2 - 1));
    assign total  = acc + step;
    assign biased = total + OFFSET;

    always_comb begin
        if (biased < 0)         clamped = '0;
        else if (biased > MAXV) clamped = '1;
        else                    clamped = biased[NTOT-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            B_IDLE:    if (ho_load) state_nxt = B_COLLECT;
            B_COLLECT: begin
                if (ho_load)   state_nxt = B_COLLECT;
                else if (last) state_nxt = B_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            acc       <= '0;
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            res_valid <= last;
            if (last) res_word <= clamped;
            if (ho_load) begin
                acc <= ho_sum;
                cnt <= '0;
            end else if (take) begin
                acc <= total;
                cnt <= cnt + CW'(1);
            end
        end
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == B_IDLE && !ho_load) |=> !res_valid);
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ho_load |=> (state == B_COLLECT && cnt == '0 && !res_valid));
    a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_word));
endmodule

// File: rtl/redundant_digit_combiner.sv
module redundant_digit_combiner #(
    parameter int STAGE1_DIGITS = 4,
    parameter int STAGE2_DIGITS = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   s1_stb,
    input  logic [1:0]                             s1_code,
    input  logic                                   xfer_on,
    input  logic                                   s2_stb,
    input  logic [1:0]                             s2_code,
    output logic                                   res_valid,
    output logic [STAGE1_DIGITS+STAGE2_DIGITS-1:0] res_word,
    output logic                                   code_err
);
    localparam int NTOT = STAGE1_DIGITS + STAGE2_DIGITS;
    localparam int SW   = NTOT + 2;

    logic                 p1, n1, b1, p2, n2, b2;
    logic                 ho_load;
    logic signed [SW-1:0] ho_sum;
    logic                 err_q;

    rdc_decode u_dec1 (.code(s1_code), .is_pos(p1), .is_neg(n1), .is_bad(b1));
    rdc_decode u_dec2 (.code(s2_code), .is_pos(p2), .is_neg(n2), .is_bad(b2));

    rdc_front #(.N1(STAGE1_DIGITS), .NTOT(NTOT), .SW(SW)) u_front (
        .clk(clk), .rst_n(rst_n), .dig_stb(s1_stb), .dig_pos(p1), .dig_neg(n1),
        .xfer_on(xfer_on), .ho_load(ho_load), .ho_sum(ho_sum)
    );

    rdc_back #(.N2(STAGE2_DIGITS), .NTOT(NTOT), .SW(SW)) u_back (
        .clk(clk), .rst_n(rst_n), .ho_load(ho_load), .ho_sum(ho_sum),
        .dig_stb(s2_stb), .dig_pos(p2), .dig_neg(n2),
        .res_valid(res_valid), .res_word(res_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | (s1_stb & b1) | (s2_stb & b2);
    end
    assign code_err = err_q;

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> code_err);
    a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_stb && s1_code == 2'b10) |=> code_err);
endmodule

// File: tb/redundant_digit_combiner_bench.sv
module redundant_digit_combiner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s1_stb = 1'b0, xfer_on = 1'b0, s2_stb = 1'b0;
    logic [1:0]  s1_code = 2'b01, s2_code = 2'b01;
    logic        res_valid, code_err;
    logic [11:0] res_word;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    redundant_digit_combiner u_redundant_digit_combiner (
        .clk(clk), .rst_n(rst_n), .s1_stb(s1_stb), .s1_code(s1_code),
        .xfer_on(xfer_on), .s2_stb(s2_stb), .s2_code(s2_code),
        .res_valid(res_valid), .res_word(res_word), .code_err(code_err)
    );

    function automatic int dval(input logic [1:0] c);
        case (c)
            2'b00:   return -1;
            2'b11:   return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_word(input logic [7:0] a, input int n1, input logic [15:0] b);
        int s = 2048;
        for (int i = 0; i < n1; i++) s += dval(a[2*i +: 2]) * (1 << (11 - i));
        for (int j = 0; j < 8; j++)  s += dval(b[2*j +: 2]) * (1 << (7 - j));
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        return s;
    endfunction

    function automatic logic [1:0] rnd_code();
        case ($urandom_range(2))
            0:       return 2'b00;
            1:       return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    task automatic drive(input logic v1, input logic [1:0] c1, input logic x,
                         input logic v2, input logic [1:0] c2);
        @(negedge clk);
        s1_stb = v1; s1_code = c1; xfer_on = x; s2_stb = v2; s2_code = c2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input string req, input logic [7:0] a, input int n1,
                           input bit extra, input logic [15:0] b);
        for (int i = 0; i < n1; i++) drive(1, a[2*i +: 2], 0, 0, 2'b01);
        if (extra) drive(1, 2'b11, 0, 0, 2'b01);
        drive(0, 2'b01, 1, 0, 2'b01);
        drive(0, 2'b01, 0, 1, 2'b11);
        for (int j = 0; j < 8; j++) drive(0, 2'b01, 0, 1, b[2*j +: 2]);
        drive(0, 2'b01, 0, 0, 2'b01);
        check({req, " valid"}, int'(res_valid), 1);
        check({req, " word"}, int'(res_word), ref_word(a, n1, b));
        drive(0, 2'b01, 0, 1, 2'b11);
        check({req, " R7 pulse end"}, int'(res_valid), 0);
        drive(0, 2'b01, 0, 0, 2'b01);
        check({req, " R8 stray digit"}, int'(res_valid), 0);
        check({req, " R7 word hold"}, int'(res_word), ref_word(a, n1, b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  a, a2;
        logic [15:0] b, b2;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(res_valid), 0);
        check("R1 word in reset", int'(res_word), 0);
        @(negedge clk); rst_n = 1'b1;
        check("R1 valid", int'(res_valid), 0);
        check("R1 err", int'(code_err), 0);

        // R8: second-stage digits with nothing pending
        for (int k = 0; k < 10; k++) begin
            drive(0, 2'b01, 0, 1, 2'b11);
            check("R8 nothing pending", int'(res_valid), 0);
        end
        drive(0, 2'b01, 0, 0, 2'b01);

        // R2: mixed directed pixel
        convert("R2 directed", 8'b00_11_01_11, 4, 0, 16'b01_00_11_01_00_11_01_11);
        // R3: clamp at both ends, and exact top
        convert("R3 clamp high", 8'hFF, 4, 0, 16'hFFFF);
        convert("R3 clamp low", 8'h00, 4, 0, 16'h0000);
        convert("R3 exact top", 8'b11_11_11_01, 4, 0, 16'hFFFF);
        // R5: fifth first-stage digit ignored
        convert("R5 extra digit", 8'b01_01_00_01, 4, 1, 16'b01_01_01_01_01_01_01_01);
        // R10: short first stage
        convert("R10 two digits", 8'b00_00_11_00, 2, 0, 16'b11_00_01_11_00_01_11_00);
        check("R9 no err yet", int'(code_err), 0);

        // R9: illegal code counts as zero, sticky
        convert("R9 illegal", 8'b11_10_01_11, 4, 0, 16'b01_11_01_11_01_11_01_10);
        check("R9 err set", int'(code_err), 1);

        // R4 R6: overlapped pixels, next digit in the hand-off cycle
        a = 8'b11_00_01_11; b = 16'b00_11_01_00_11_11_01_00;
        a2 = 8'b00_11_00_00; b2 = 16'b11_01_00_11_01_00_11_11;
        for (int i = 0; i < 4; i++) drive(1, a[2*i +: 2], 0, 0, 2'b01);
        drive(0, 2'b01, 1, 0, 2'b01);
        drive(1, a2[1:0], 0, 1, 2'b00);
        for (int j = 0; j < 8; j++)
            drive(j < 3, (j < 3) ? a2[2*(j+1) +: 2] : 2'b01, j >= 6, 1, b[2*j +: 2]);
        drive(0, 2'b01, 0, 0, 2'b01);
        check("R6 first valid", int'(res_valid), 1);
        check("R6 first word", int'(res_word), ref_word(a, 4, b));
        for (int j = 0; j < 8; j++) drive(0, 2'b01, 0, 1, b2[2*j +: 2]);
        drive(0, 2'b01, 0, 0, 2'b01);
        check("R4 second valid", int'(res_valid), 1);
        check("R4 second word", int'(res_word), ref_word(a2, 4, b2));

        // R11: restart during second-stage collection
        a = 8'b11_11_11_11; a2 = 8'b01_00_11_01;
        b2 = 16'b00_01_11_11_00_01_11_00;
        for (int i = 0; i < 4; i++) drive(1, a[2*i +: 2], 0, 0, 2'b01);
        drive(0, 2'b01, 1, 0, 2'b01);
        drive(0, 2'b01, 0, 0, 2'b01);
        for (int i = 0; i < 4; i++) drive(1, a2[2*i +: 2], 0, i < 3, 2'b11);
        drive(0, 2'b01, 1, 0, 2'b01);
        drive(0, 2'b01, 0, 1, 2'b11);
        check("R11 no pulse", int'(res_valid), 0);
        for (int j = 0; j < 8; j++) drive(0, 2'b01, 0, 1, b2[2*j +: 2]);
        drive(0, 2'b01, 0, 0, 2'b01);
        check("R11 valid", int'(res_valid), 1);
        check("R11 word", int'(res_word), ref_word(a2, 4, b2));

        // R2: random pixels
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < 4; i++) a[2*i +: 2] = rnd_code();
            for (int j = 0; j < 8; j++) b[2*j +: 2] = rnd_code();
            convert("R2 random", a, 4, 0, b);
        end
        check("R9 err still set", int'(code_err), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule